// File: doc/BRIEF.md
# Supervisor Reset Output Controller

This block produces the active-low reset for a multi-rail voltage supervisor. It drives an open-drain pin, so it only ever decides whether the pull-down is on. An external pull-up raises the line whenever the pull-down is off.

After power-up, and after every synchronous reset, the pull-down stays on until the self-test logic reports that it is done. From then on, the pull-down turns on whenever an overvoltage or undervoltage flag is raised on a channel whose enable bit is set in the mapping inputs. Once every enabled fault has gone away, the pull-down stays on for a hold time picked by a 3-bit code. Only then is it turned off.

The sampled pin level is passed through a two-stage synchronizer and compared with the driven state. A comparison window that is blanked after every change of drive lets a pin held by something outside be reported as a sticky mismatch. The mismatch is cleared by a write-one-to-clear pulse.

Top module: `sup_rst_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until `bist_done` is sampled high, `pull_en` is 1 and `mm_flt` is 0.
- R2: When `bist_done` is sampled high with no enabled fault present, `pull_en` drops to 0 after that clock edge and stays 0. If an enabled fault is present at that edge, the block behaves as in R3 and R4 instead.
- R3: Fault bit `ov_flt[i]` counts only when `ov_map[i]` is 1, and `uv_flt[i]` counts only when `uv_map[i]` is 1. An enabled fault sets `pull_en` to 1 after the next clock edge. A fault whose map bit is 0 has no effect on `pull_en`.
- R4: After all enabled faults clear, `pull_en` stays 1 for exactly N clock cycles and then drops to 0. N = CLK_HZ × T / 1000, where T in ms is set by `dly_code`: 0→0.2, 1→1, 2→2, 3→5, 4→10, 5→20, 6→100, 7→200.
- R5: If an enabled fault returns while the hold time is running, the count is abandoned. The full N cycles are counted again from the next time all faults clear.
- R6: `mm_flt` is set when the synchronized pin level differs from the driven state. A pin read low while `pull_en` is 0 is a mismatch, and so is a pin read high while `pull_en` is 1.
- R7: For 2 µs plus the two synchronizer cycles after any change of `pull_en`, no mismatch is recorded. A mismatch that persists beyond that window is recorded.
- R8: `mm_flt` stays set until `mm_clr` is sampled high, and it is 0 in the cycle after that edge. If the mismatch condition persists, the flag is set again.
- R9: Sampling `rst_n` low at any time returns the block to the power-up state, with `pull_en` at 1 waiting for `bist_done` and `mm_flt` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock of CLK_HZ nominal frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| bist_done | input | 1 | Self-test complete |
| ov_flt | input | CH | Per-channel overvoltage flags |
| uv_flt | input | CH | Per-channel undervoltage flags |
| ov_map | input | CH | Per-channel enable of overvoltage flag onto reset |
| uv_map | input | CH | Per-channel enable of undervoltage flag onto reset |
| dly_code | input | 3 | Release hold time select |
| pin_in | input | 1 | Observed level of the reset pin (asynchronous) |
| mm_clr | input | 1 | Write-one-to-clear pulse for the mismatch flag |
| pull_en | output | 1 | 1 = pull the reset pin low, 0 = high-impedance |
| mm_flt | output | 1 | Sticky pin mismatch fault |

## Verification
The bench targets the exact length of the hold time for several codes. A counter that is off by one shows up as a release one cycle early or late. A fault that comes back in the middle of the count must restart it; a design that only paused the count would release early. Unmapped faults are raised on every channel to catch an enable applied to the wrong lane. A pin stuck low across a release checks the blanking window: a design that compared without blanking would flag every normal toggle, and one with no comparison would never flag the stuck pin. The sticky flag and its clear are exercised, including a clear issued while the fault persists.

// File: rtl/sr_pkg.sv
// Shared definitions for the supervisor reset output controller.
// Assumes clock frequencies given in Hz, with times computed in 64-bit math.
package sr_pkg;

    typedef enum logic [1:0] {ST_BOOT, ST_RUN, ST_HOLD, ST_DLY} rst_st_t;

    // Hold time in clock ticks for a 3-bit code (units of 0.1 ms).
    function automatic longint dly_ticks(input int unsigned code, input longint hz);
        longint tenths;
        case (code)
            0: tenths = 2;
            1: tenths = 10;
            2: tenths = 20;
            3: tenths = 50;
            4: tenths = 100;
            5: tenths = 200;
            6: tenths = 1000;
            default: tenths = 2000;
        endcase
        dly_ticks = (hz * tenths) / 10000;
        if (dly_ticks < 1) dly_ticks = 1;
    endfunction

    // Number of ticks covering 2 us, at least one.
    function automatic longint blank_ticks(input longint hz);
        blank_ticks = (hz * 2) / 1000000;
        if (blank_ticks < 1) blank_ticks = 1;
    endfunction

endpackage

// File: rtl/sr_fault_merge.sv
// Combines per-channel overvoltage/undervoltage flags with their enable bits.
// Assumes the flags are already synchronous to clk.
module sr_fault_merge #(
    parameter int CH = 4
) (
    input  logic [CH-1:0] ov_flt,
    input  logic [CH-1:0] uv_flt,
    input  logic [CH-1:0] ov_map,
    input  logic [CH-1:0] uv_map,
    output logic          any_flt
);
    logic [CH-1:0] hit;

    // One lane per channel: a flag counts only when its enable is set.
    for (genvar i = 0; i < CH; i++) begin : g_lane
        assign hit[i] = (ov_flt[i] & ov_map[i]) | (uv_flt[i] & uv_map[i]);
    end

    assign any_flt = |hit;
endmodule

// File: rtl/sr_rst_seq.sv
// Reset sequencer: holds reset through self-test, asserts it on faults and
// keeps it asserted for a coded hold time after faults clear.
// Assumes dly_code stays steady while a hold time is counted.
module sr_rst_seq
    import sr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bist_done,
    input  logic       any_flt,
    input  logic [2:0] dly_code,
    output logic       pull_en
);
    localparam longint MAX_T = dly_ticks(7, longint'(CLK_HZ));
    localparam int     CW    = $clog2(MAX_T + 1);

    rst_st_t        state_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  lim_tab [8];
    logic [CW-1:0]  lim;

    // Tick limit for each code, computed at elaboration.
    for (genvar g = 0; g < 8; g++) begin : g_lim
        assign lim_tab[g] = CW'(dly_ticks(g, longint'(CLK_HZ)));
    end

    assign lim     = lim_tab[dly_code];
    assign pull_en = (state_q != ST_RUN);

    // State and hold-time counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_BOOT: if (bist_done) state_q <= any_flt ? ST_HOLD : ST_RUN;
                ST_RUN:  if (any_flt) state_q <= ST_HOLD;
                ST_HOLD: if (!any_flt) begin
                    state_q <= ST_DLY;
                    cnt_q   <= '0;
                end
                default: begin
                    if (any_flt)                   state_q <= ST_HOLD;
                    else if (cnt_q >= lim - CW'(1)) state_q <= ST_RUN;
                    else                           cnt_q   <= cnt_q + CW'(1);
                end
            endcase
        end
    end

    a_r1_boot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT && !bist_done) |=> pull_en);
    a_r3_fault_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        any_flt |=> pull_en);
    a_r4_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DLY && !any_flt && cnt_q < lim - CW'(1)) |=> pull_en);
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DLY && any_flt) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/sr_pin_check.sv
// Pin readback: synchronizes the pin level, blanks comparison after each
// change of drive, and keeps a sticky mismatch flag with write-one-to-clear.
// Assumes an external pull-up, so a released pin should read high.
module sr_pin_check
    import sr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int          SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pull_en,
    input  logic pin_in,
    input  logic mm_clr,
    output logic mm_flt
);
    localparam int WIN = int'(blank_ticks(longint'(CLK_HZ))) + SYNC_N;
    localparam int BW  = $clog2(WIN + 1);

    logic [SYNC_N-1:0] sync_q;
    logic              drv_q;
    logic [BW-1:0]     blank_q;
    logic              mm_q;
    logic              toggle, err;

    assign toggle = drv_q ^ pull_en;
    assign err    = !toggle && (blank_q == '0) && (sync_q[SYNC_N-1] == pull_en);
    assign mm_flt = mm_q;

    // Synchronizer, drive history, blanking counter and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= '0;
            drv_q   <= 1'b1;
            blank_q <= BW'(WIN);
            mm_q    <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin_in};
            drv_q  <= pull_en;
            if (toggle)              blank_q <= BW'(WIN);
            else if (blank_q != '0)  blank_q <= blank_q - BW'(1);
            if (mm_clr)   mm_q <= 1'b0;
            else if (err) mm_q <= 1'b1;
        end
    end

    a_r7_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_q != '0 || toggle) |=> !$rose(mm_q));
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_q && !mm_clr) |=> mm_q);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mm_clr |=> !mm_q);
endmodule

// File: rtl/sup_rst_ctrl.sv
// Top of the supervisor reset output controller: fault merge, reset
// sequencer and pin readback. Assumes fault flags synchronous to clk.
module sup_rst_ctrl #(
    parameter int          CH     = 4,
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bist_done,
    input  logic [CH-1:0] ov_flt,
    input  logic [CH-1:0] uv_flt,
    input  logic [CH-1:0] ov_map,
    input  logic [CH-1:0] uv_map,
    input  logic [2:0]    dly_code,
    input  logic          pin_in,
    input  logic          mm_clr,
    output logic          pull_en,
    output logic          mm_flt
);
    logic any_flt;

    sr_fault_merge #(.CH(CH)) u_merge (
        .ov_flt(ov_flt), .uv_flt(uv_flt), .ov_map(ov_map), .uv_map(uv_map),
        .any_flt(any_flt)
    );

    sr_rst_seq #(.CLK_HZ(CLK_HZ)) u_seq (
        .clk(clk), .rst_n(rst_n), .bist_done(bist_done), .any_flt(any_flt),
        .dly_code(dly_code), .pull_en(pull_en)
    );

    sr_pin_check #(.CLK_HZ(CLK_HZ), .SYNC_N(2)) u_pin (
        .clk(clk), .rst_n(rst_n), .pull_en(pull_en), .pin_in(pin_in),
        .mm_clr(mm_clr), .mm_flt(mm_flt)
    );

    a_r9_reset_state: assert property (@(posedge clk) !rst_n |=> (pull_en && !mm_flt));
endmodule

// File: tb/sim_sup_rst_ctrl.sv
module sim_sup_rst_ctrl;
    localparam int CH = 4;
    localparam int unsigned HZ = 2_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0, bist_done = 1'b0, mm_clr = 1'b0;
    logic [CH-1:0] ov_flt = '0, uv_flt = '0, ov_map = '0, uv_map = '0;
    logic [2:0] dly_code = 3'd0;
    logic ext_low = 1'b0, ext_high = 1'b0;
    logic pin_in, pull_en, mm_flt;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    assign pin_in = ext_high ? 1'b1 : (ext_low ? 1'b0 : ~pull_en);

    sup_rst_ctrl #(.CH(CH), .CLK_HZ(HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .bist_done(bist_done), .ov_flt(ov_flt),
        .uv_flt(uv_flt), .ov_map(ov_map), .uv_map(uv_map), .dly_code(dly_code),
        .pin_in(pin_in), .mm_clr(mm_clr), .pull_en(pull_en), .mm_flt(mm_flt)
    );

    function automatic int ticks(input int code);
        real ms [8] = '{0.2, 1.0, 2.0, 5.0, 10.0, 20.0, 100.0, 200.0};
        return int'(real'(HZ) * ms[code] / 1000.0);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference of the drive state, stepped on every edge.
    int m_st = 0, m_left = 0;
    bit m_on = 0;
    always @(posedge clk) begin
        bit any;
        any = |((ov_flt & ov_map) | (uv_flt & uv_map));
        if (!rst_n) begin m_st = 0; m_on = 1; end
        else case (m_st)
            0: if (bist_done) m_st = any ? 2 : 1;
            1: if (any) m_st = 2;
            2: if (!any) begin m_st = 3; m_left = ticks(int'(dly_code)); end
            default: if (any) m_st = 2;
                     else if (m_left <= 1) m_st = 1;
                     else m_left--;
        endcase
    end
    always @(negedge clk) if (m_on && !done) chk("R4 per-cycle drive", int'(pull_en), int'(m_st != 1));

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input string req, input int exp_n);
        int n = 0;
        ov_flt = '0; uv_flt = '0;
        @(negedge clk);
        while (pull_en) begin n++; @(negedge clk); end
        chk(req, n, exp_n);
    endtask

    task automatic clr_mm();
        mm_clr = 1'b1; @(negedge clk); mm_clr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk("R1 reset pull", int'(pull_en), 1);
        chk("R1 reset mm", int'(mm_flt), 0);
        rst_n = 1'b1;
        cyc(20);
        chk("R1 wait bist", int'(pull_en), 1);
        chk("R1 no mm in boot", int'(mm_flt), 0);
        bist_done = 1'b1;
        cyc(1);
        chk("R2 release", int'(pull_en), 0);
        cyc(20);
        chk("R2 stays released", int'(pull_en), 0);
        chk("R7 no mm on normal toggle", int'(mm_flt), 0);

        // R3: unmapped faults on every lane have no effect
        ov_flt = '1; uv_flt = '1; ov_map = '0; uv_map = '0;
        cyc(10);
        chk("R3 unmapped ignored", int'(pull_en), 0);
        ov_flt = '0; uv_flt = '0;
        ov_map = 4'b0010;
        ov_flt = 4'b1101;
        cyc(5);
        chk("R3 other lanes ignored", int'(pull_en), 0);
        ov_flt = 4'b0010;
        cyc(1);
        chk("R3 mapped ov asserts", int'(pull_en), 1);
        cyc(30);
        measure("R4 code0 hold", ticks(0));
        cyc(20);
        chk("R7 no mm after delay toggles", int'(mm_flt), 0);

        // R4 code 1 with an undervoltage on channel 3
        dly_code = 3'd1; uv_map = 4'b1000; uv_flt = 4'b1000;
        cyc(1);
        chk("R3 mapped uv asserts", int'(pull_en), 1);
        cyc(10);
        measure("R4 code1 hold", ticks(1));

        // R5 restart on fault return
        dly_code = 3'd0; ov_flt = 4'b0010;
        cyc(10);
        ov_flt = '0;
        cyc(200);
        chk("R5 still holding", int'(pull_en), 1);
        ov_flt = 4'b0010;
        cyc(5);
        measure("R5 full restart", ticks(0));

        // R4 code 3
        dly_code = 3'd3; uv_flt = 4'b1000;
        cyc(5);
        measure("R4 code3 hold", ticks(3));
        cyc(10);
        chk("R7 no spurious mm", int'(mm_flt), 0);

        // R6 released pin pulled low externally
        ext_low = 1'b1;
        cyc(5);
        chk("R6 low while released", int'(mm_flt), 1);
        ext_low = 1'b0;
        cyc(20);
        chk("R8 sticky", int'(mm_flt), 1);
        clr_mm();
        chk("R8 cleared", int'(mm_flt), 0);
        cyc(10);
        chk("R8 stays clear", int'(mm_flt), 0);

        // R8 clear while the condition persists
        ext_low = 1'b1;
        cyc(5);
        clr_mm();
        chk("R8 clear takes priority", int'(mm_flt), 0);
        cyc(3);
        chk("R8 re-raised", int'(mm_flt), 1);
        ext_low = 1'b0;
        cyc(5);
        clr_mm();

        // R6 driven pin read high
        dly_code = 3'd0; ov_flt = 4'b0010;
        cyc(20);
        chk("R6 no mm while driving", int'(mm_flt), 0);
        ext_high = 1'b1;
        cyc(5);
        chk("R6 high while driven", int'(mm_flt), 1);
        ext_high = 1'b0;
        cyc(5);
        clr_mm();

        // R7 pin stuck low across a release
        ext_low = 1'b1;
        cyc(5);
        chk("R7 consistent low", int'(mm_flt), 0);
        ov_flt = '0;
        @(negedge clk);
        while (pull_en) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            chk("R7 blanked after toggle", int'(mm_flt), 0);
            @(negedge clk);
        end
        cyc(10);
        chk("R7 flagged after window", int'(mm_flt), 1);
        ext_low = 1'b0;
        cyc(5);
        clr_mm();

        // R9 reset mid-run, then R2 with a fault present at self-test done
        bist_done = 1'b0; ov_flt = 4'b0010; ext_low = 1'b1;
        cyc(10);
        chk("R6 setup mm", int'(mm_flt), 0);
        ov_flt = '0;
        cyc(ticks(0) + 12);
        chk("R6 setup mm raised", int'(mm_flt), 1);
        ext_low = 1'b0;
        rst_n = 1'b0;
        cyc(1);
        chk("R9 pull after reset", int'(pull_en), 1);
        chk("R9 mm after reset", int'(mm_flt), 0);
        rst_n = 1'b1;
        cyc(10);
        chk("R9 waits for bist", int'(pull_en), 1);
        uv_flt = 4'b1000; bist_done = 1'b1;
        cyc(10);
        chk("R2 fault at bist holds", int'(pull_en), 1);
        measure("R2 fault at bist then hold", ticks(0));
        cyc(10);
        chk("R7 no mm at end", int'(mm_flt), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule